// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the fast system clock. It is programmed with one 32-bit configuration word. The top bit selects a pass-through mode, in which the serial clock is the system clock itself. The low bits hold three 6-bit counter fields:

- a terminal count, which sets the period;
- a rise point, where the serial clock goes high;
- a fall point, where it returns low.

In divided mode a counter walks from 0 to the terminal count and wraps. The output level is registered, so it is free of glitches.

Next to the level, the block gives two strobes one system cycle wide. One warns that the level rises at the next edge, the other that it falls. The transfer sequencer uses them to launch and capture data. The usual setting for a divide factor N puts N-1 in the terminal count, N/2-1 in the rise point and N-1 in the fall point. This gives an even duty cycle for even N. With an 80 MHz system clock the usual factors give the common SPI rates.

A new configuration word is taken at the next wrap of the counter, so a rewrite during a transfer never shortens a phase. Dropping the enable returns the block to idle. On the next enable it starts at count 0 with the word then present.

Top module: `spi_sclk_div`

## Requirements
- R1: When bit 31 of the applied word is 1 and the block runs, `sclk_o` follows `clk_i` (high in the high phase, low in the low phase), and `rise_o` and `fall_o` are both 1 in every cycle.
- R2: In divided mode the output pattern repeats every T+1 cycles, where T is bits [5:0], and the counter never exceeds T.
- R3: Within a period, with H in bits [11:6] and L in bits [17:12] (H < L <= T), `sclk_o` is 0 at counts 0..H, 1 at counts H+1..L, and 0 at counts above L.
- R4: `rise_o` is 1 for exactly the one cycle before `sclk_o` changes from 0 to 1, and at no other time in divided mode.
- R5: `fall_o` is 1 for exactly the one cycle before `sclk_o` changes from 1 to 0, and at no other time in divided mode.
- R6: One cycle after `en_i` goes low, `sclk_o`, `rise_o` and `fall_o` are 0. The first cycle after `en_i` returns high is count 0.
- R7: A word written to `cfg_i` while running takes effect only at the first count 0 after the current period completes. This includes switching into and out of pass-through mode.
- R8: If H is greater than T, the level never rises and no strobe is given.
- R9: While `rst_ni` is low, `sclk_o`, `rise_o` and `fall_o` are 0.
- R10: A word presented together with the enable governs the very first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request for the serial clock |
| cfg_i | input | 32 | Configuration word: pass-through bit, terminal count, rise point, fall point |
| sclk_o | output | 1 | Serial clock level |
| rise_o | output | 1 | Strobe: the level rises at the next edge |
| fall_o | output | 1 | Strobe: the level falls at the next edge |

## Verification
A counter that is off by one shows within one period as a stretched or shortened high or low phase. The scoreboard compares the strobes and the level in every cycle, so such a fault is reported at the first cycle it touches. A configuration register loaded at the wrong moment shows as a period of mixed length right after the write, so a change made mid-period is checked cycle by cycle. A level register that is not cleared shows in the first cycle after disable or re-enable.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  localparam int SCLK_CFG_W   = 32;
  localparam int SCLK_CNT_W   = 6;
  localparam int SCLK_BYP_BIT = SCLK_CFG_W - 1;
  localparam int SCLK_HI_LSB  = SCLK_CNT_W;
  localparam int SCLK_LO_LSB  = 2 * SCLK_CNT_W;
  localparam int SCLK_LO_MSB  = SCLK_LO_LSB + SCLK_CNT_W - 1;

  typedef logic [SCLK_CNT_W-1:0] sclk_cnt_t;

  typedef struct packed {
    logic      byp;
    sclk_cnt_t term;
    sclk_cnt_t hi;
    sclk_cnt_t lo;
  } sclk_cfg_t;

  // Field split of the configuration word.
  function automatic sclk_cfg_t sclk_unpack(input logic [SCLK_CFG_W-1:0] w);
    sclk_cfg_t c;
    c.byp  = w[SCLK_BYP_BIT];
    c.term = w[SCLK_HI_LSB-1:0];
    c.hi   = w[SCLK_LO_LSB-1:SCLK_HI_LSB];
    c.lo   = w[SCLK_LO_MSB:SCLK_LO_LSB];
    return c;
  endfunction

  // Last count of a period; in pass-through every cycle closes a period.
  function automatic logic sclk_at_wrap(input sclk_cfg_t c, input sclk_cnt_t n);
    return c.byp || (n == c.term);
  endfunction

  function automatic sclk_cnt_t sclk_step(input sclk_cfg_t c, input sclk_cnt_t n);
    return sclk_at_wrap(c, n) ? '0 : sclk_cnt_t'(n + 1'b1);
  endfunction
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import spi_sclk_pkg::*;
#(
  parameter int CFG_W = SCLK_CFG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CFG_W-1:0] word_i,
  output sclk_cfg_t        cfg_o
);
  sclk_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= sclk_unpack(word_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sclk_phase_cnt.sv
module sclk_phase_cnt
  import spi_sclk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      go_i,
  input  sclk_cfg_t cfg_i,
  output sclk_cnt_t cnt_o,
  output logic      wrap_o
);
  sclk_cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!go_i) cnt_q <= '0;
    else            cnt_q <= sclk_step(cfg_i, cnt_q);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = go_i && sclk_at_wrap(cfg_i, cnt_q);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !cfg_i.byp) |-> (cnt_q <= cfg_i.term)); // R2
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen
  import spi_sclk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      go_i,
  input  sclk_cfg_t cfg_i,
  input  sclk_cnt_t cnt_i,
  output logic      level_o,
  output logic      rise_o,
  output logic      fall_o
);
  logic level_q;
  logic hit_hi, hit_lo, div_run;

  assign div_run = go_i && !cfg_i.byp;
  assign hit_hi  = (cnt_i == cfg_i.hi);
  assign hit_lo  = (cnt_i == cfg_i.lo);
  // A strobe marks a real change at the next edge.
  assign rise_o  = div_run && hit_hi && !hit_lo && !level_q;
  assign fall_o  = div_run && hit_lo && level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       level_q <= 1'b0;
    else if (!div_run) level_q <= 1'b0;
    else if (rise_o)   level_q <= 1'b1;
    else if (fall_o)   level_q <= 1'b0;
  end

  assign level_o = level_q;

  AST_RISE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> level_o); // R4
  AST_FALL_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !level_o); // R5
endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div
  import spi_sclk_pkg::*;
#(
  parameter int CFG_W = SCLK_CFG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic      run_q, go, wrap, load, byp_run;
  logic      div_level, div_rise, div_fall;
  sclk_cfg_t act_cfg;
  sclk_cnt_t cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  assign go   = en_i && run_q;
  // Idle: track the word; running: take it only at the end of a period.
  assign load = !run_q || wrap;

  sclk_cfg_hold #(.CFG_W(CFG_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .word_i(cfg_i),
    .cfg_o (act_cfg)
  );

  sclk_phase_cnt u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .cfg_i (act_cfg),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  sclk_edge_gen u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .cfg_i  (act_cfg),
    .cnt_i  (cnt),
    .level_o(div_level),
    .rise_o (div_rise),
    .fall_o (div_fall)
  );

  assign byp_run = go && act_cfg.byp;
  assign sclk_o  = byp_run ? clk_i : div_level;
  assign rise_o  = byp_run || div_rise;
  assign fall_o  = byp_run || div_fall;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt == '0 && !div_level && !rise_o && !fall_o)); // R6
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !$past(wrap)) |-> $stable(act_cfg)); // R7
  AST_BYP_NO_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_run |-> !div_level); // R1
endmodule

// File: tb/spi_sclk_div_test.sv
`timescale 1ns/1ps
module spi_sclk_div_test;
  typedef struct {
    logic  hi;
    logic  lo;
    logic  r;
    logic  f;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] cfg = '0;
  logic        sclk, rise, fall;
  logic        hi_s = 1'b0;
  item_t       q[$];
  int          n_vec = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  spi_sclk_div uut (
    .clk_i (clk),
    .rst_ni(rst_n),
    .en_i  (en),
    .cfg_i (cfg),
    .sclk_o(sclk),
    .rise_o(rise),
    .fall_o(fall)
  );

  function automatic logic [31:0] word_div(input int n);
    if (n == 1) return 32'h8000_0000;
    return (32'(n - 1) << 12) | (32'(n / 2 - 1) << 6) | 32'(n - 1);
  endfunction

  function automatic logic [31:0] word_raw(input int t, input int h, input int l);
    return (32'(l) << 12) | (32'(h) << 6) | 32'(t);
  endfunction

  function automatic logic lvl(input int k, input int h, input int l);
    return (k > h) && (k <= l);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: sample the high phase after each rising edge, the rest at the falling edge.
  always @(posedge clk) begin
    #1 hi_s = sclk;
  end

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, hi_s, it.hi, "sclk high phase");
      chk(it.tag, sclk, it.lo, "sclk low phase");
      chk(it.tag, rise, it.r,  "rise strobe");
      chk(it.tag, fall, it.f,  "fall strobe");
    end
  end

  // Driver: push the expected cycles for nper periods of word w.
  // When chg is set, nxt is written just after count 1 of the last period
  // (count 0 for a one-cycle period).
  task automatic run_cfg(input logic [31:0] w, input int nper, input logic [31:0] nxt,
                         input bit chg, input string tag);
    int t = int'(w[5:0]);
    int h = int'(w[11:6]);
    int l = int'(w[17:12]);
    bit b = w[31];
    int len = b ? 1 : t + 1;
    for (int p = 0; p < nper; p++) begin
      for (int k = 0; k < len; k++) begin
        item_t it;
        int kn = (k == t) ? 0 : k + 1;
        it.tag = tag;
        if (b) begin
          it.hi = 1'b1; it.lo = 1'b0; it.r = 1'b1; it.f = 1'b1;
        end else begin
          it.hi = lvl(k, h, l);
          it.lo = it.hi;
          it.r  = !lvl(k, h, l) && lvl(kn, h, l);
          it.f  = lvl(k, h, l) && !lvl(kn, h, l);
        end
        q.push_back(it);
        @(negedge clk); #1;
        if (chg && p == nper - 1 && k == ((len > 1) ? 1 : 0)) cfg = nxt;
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.hi = 1'b0; it.lo = 1'b0; it.r = 1'b0; it.f = 1'b0; it.tag = tag;
      q.push_back(it);
      @(negedge clk); #1;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9", sclk, 1'b0, "reset sclk");
    chk("R9", rise, 1'b0, "reset rise");
    chk("R9", fall, 1'b0, "reset fall");
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R10: word given with the enable governs the first period.
    cfg = word_div(4); en = 1'b1;
    run_cfg(word_div(4), 3, word_div(3), 1, "R10_R2_R3_R4_R5");
    // R7: the change made mid-period waits for the wrap.
    run_cfg(word_div(3), 2, word_raw(9, 2, 6), 1, "R7_odd_R3");
    run_cfg(word_raw(9, 2, 6), 2, word_div(1), 1, "R7_asym_R3");
    run_cfg(word_div(1), 4, word_div(2), 1, "R1_bypass");
    run_cfg(word_div(2), 3, 32'h0, 0, "R7_leave_bypass_R2");

    // R6: disable clears; re-enable starts at count 0.
    en = 1'b0;
    idle(3, "R6_off");
    cfg = word_div(64); en = 1'b1;
    run_cfg(word_div(64), 2, 32'h0, 0, "R6_restart_R2_max");

    // R8: rise point beyond the terminal count.
    en = 1'b0;
    idle(2, "R6_off2");
    cfg = word_raw(5, 7, 5); en = 1'b1;
    run_cfg(word_raw(5, 7, 5), 2, 32'h0, 0, "R8_no_rise");

    en = 1'b0;
    idle(1, "R6_final");
    wait (q.size() == 0);
    @(negedge clk); #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule